// File: doc/BRIEF.md
# Partitioned Pixel Pack and Merge Unit

This unit reformats packed pixel data held in 64-bit words. A 9-bit operation code selects one of five formatting operations: squeezing four signed 16-bit lanes into unsigned bytes, squeezing two signed 32-bit lanes into bytes while shifting the first operand left into place, reducing two signed 32-bit lanes to saturated 16-bit values, widening four bytes into 16-bit fixed-point values, and interleaving the bytes of two 32-bit words. The three pack operations scale each lane by a left shift. The shift amount comes from a field of a graphics status word that starts at bit 3.

A caller presents both operands, the status word and the code, and raises `in_valid` for one cycle. On the next clock edge the result register loads the result, `out_valid` rises, and `narrow` shows whether only the low 32 bits carry data. An unknown code loads a zero result and raises `illegal`. When `in_valid` is low the result register keeps its value.

Top module: `pix_fmt_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Reset clears `out_valid`, `result`, `narrow` and `illegal`.
- R2: While `in_valid` is low, `result`, `narrow` and `illegal` keep their values whatever the other inputs do.
- R3: Code 0x03b (16-bit pack): each signed 16-bit lane i of `src_b` is shifted left by `status[6:3]` and then arithmetically right by 7. The value is clamped to 0..255 and lands in result byte i (bits 8i+7:8i). Bits 63:32 are zero.
- R4: Code 0x03a (32-bit pack): the result is `src_a` shifted left by 8, with bits 7:0 and 39:32 replaced. Each signed 32-bit lane w of `src_b` is shifted left by `status[7:3]`, arithmetically right by 23, clamped to 0..255, and placed in bits 32w+7:32w.
- R5: Code 0x03d (fixed-point pack): each signed 32-bit lane w of `src_b` is shifted left by `status[7:3]`, arithmetically right by 16, saturated to -32768..32767, and placed in bits 16w+15:16w. Bits 63:32 are zero.
- R6: Code 0x04d (expand): byte i of `src_b[31:0]` becomes the 16-bit value byte<<4 in bits 16i+15:16i.
- R7: Code 0x04b (merge): result byte 2k equals byte k of `src_b`, and result byte 2k+1 equals byte k of `src_a`, for k = 0..3.
- R8: `narrow` is 1 after codes 0x03b and 0x03d and 0 after every other code.
- R9: Any other code gives `result` = 0, `narrow` = 0 and `illegal` = 1. `illegal` is 0 after the five legal codes.
- R10: Status bits outside the scale field have no effect. For code 0x03b this includes bit 7.
- R11: Left shifts never overflow before the clamp. A lane at its largest magnitude shifted by the largest scale still clamps to the correct limit, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 9 | Operation code |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| status | input | 64 | Graphics status word holding the scale field |
| out_valid | output | 1 | Result loaded in this cycle |
| result | output | 64 | Registered result |
| narrow | output | 1 | Only bits 31:0 of result are meaningful |
| illegal | output | 1 | Last code was not recognised |

## Verification
The hardest cases to reach are the overflow edge of the scaled lanes: a full-magnitude negative or positive lane shifted by the largest scale, landing just outside or inside the clamp window. Random operands almost never hit these cases, so directed cases drive lanes of 0x7fff, 0x8000, 0x7fffffff and 0x80000000 with scale 15 or 31, plus values one step on either side of each clamp bound. Random stimulus then sweeps codes, operands and the whole status word, with set bits outside the scale field, and an occasional unknown code.

// File: rtl/pix_fmt_unit.sv
module pix_fmt_unit #(
  parameter int OPW = 9,
  parameter int DW = 64,
  parameter int SCALE_LSB = 3,
  parameter logic [OPW-1:0] OP_PK16 = 9'h03b,
  parameter logic [OPW-1:0] OP_PK32 = 9'h03a,
  parameter logic [OPW-1:0] OP_PKFX = 9'h03d,
  parameter logic [OPW-1:0] OP_EXPD = 9'h04d,
  parameter logic [OPW-1:0] OP_MERG = 9'h04b
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic [DW-1:0]  status,
  output logic           out_valid,
  output logic [DW-1:0]  result,
  output logic           narrow,
  output logic           illegal
);
  localparam int HW = DW / 2;
  localparam int N16 = DW / 16;
  localparam int N32 = DW / 32;

  logic [3:0] sc4;
  logic [4:0] sc5;
  assign sc4 = status[SCALE_LSB +: 4];
  assign sc5 = status[SCALE_LSB +: 5];

  logic [HW-1:0] pk16;
  logic [7:0]    pk32_byte [N32];
  logic [HW-1:0] pkfx;
  logic [DW-1:0] expd, merg;

  for (genvar g = 0; g < N16; g++) begin : g_lane16
    logic signed [31:0] ext, shl, shr;
    assign ext = {{16{src_b[16*g+15]}}, src_b[16*g +: 16]};
    assign shl = ext <<< sc4;
    assign shr = shl >>> 7;
    assign pk16[8*g +: 8] = (shr < 32'sd0)   ? 8'h00 :
                            (shr > 32'sd255) ? 8'hff : shr[7:0];
    assign expd[16*g +: 16] = {4'h0, src_b[8*g +: 8], 4'h0};
    assign merg[16*g +: 16] = {src_a[8*g +: 8], src_b[8*g +: 8]};
  end

  for (genvar w = 0; w < N32; w++) begin : g_lane32
    logic signed [63:0] ext, shl, s23, s16;
    assign ext = {{32{src_b[32*w+31]}}, src_b[32*w +: 32]};
    assign shl = ext <<< sc5;
    assign s23 = shl >>> 23;
    assign s16 = shl >>> 16;
    assign pk32_byte[w] = (s23 < 64'sd0)   ? 8'h00 :
                          (s23 > 64'sd255) ? 8'hff : s23[7:0];
    assign pkfx[16*w +: 16] = (s16 < -64'sd32768) ? 16'h8000 :
                              (s16 > 64'sd32767)  ? 16'h7fff : s16[15:0];
  end

  logic [DW-1:0] pk32_full;
  assign pk32_full = {src_a[55:32], pk32_byte[1], src_a[23:0], pk32_byte[0]};

  logic [DW-1:0] nxt;
  logic          nxt_narrow, nxt_bad;

  always_comb begin
    nxt = '0;
    nxt_narrow = 1'b0;
    nxt_bad = 1'b0;
    case (op)
      OP_PK16: begin nxt = {{HW{1'b0}}, pk16}; nxt_narrow = 1'b1; end
      OP_PK32: nxt = pk32_full;
      OP_PKFX: begin nxt = {{HW{1'b0}}, pkfx}; nxt_narrow = 1'b1; end
      OP_EXPD: nxt = expd;
      OP_MERG: nxt = merg;
      default: nxt_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result <= '0;
      narrow <= 1'b0;
      illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt;
        narrow <= nxt_narrow;
        illegal <= nxt_bad;
      end
    end
  end

  logic op_known;
  assign op_known = (op == OP_PK16) || (op == OP_PK32) || (op == OP_PKFX) ||
                    (op == OP_EXPD) || (op == OP_MERG);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(narrow) && $stable(illegal)));
  p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> (result[DW-1:HW] == '0));
  p_narrow_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_PK16 || op == OP_PKFX)) |=> narrow);
  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0 && !narrow));
  p_illegal_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (illegal == !$past(op_known)));
  p_expand_nibbles_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_EXPD) |=>
      (result[3:0] == 4'h0 && result[15:12] == 4'h0 && result[51:48] == 4'h0));
endmodule

// File: tb/sim_pix_fmt_unit.sv
`timescale 1ns/1ps
module sim_pix_fmt_unit;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [8:0] op = '0;
  logic [63:0] src_a = '0, src_b = '0, status = '0;
  logic out_valid, narrow, illegal;
  logic [63:0] result;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pix_fmt_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .status(status), .out_valid(out_valid),
    .result(result), .narrow(narrow), .illegal(illegal));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] clamp8(input longint v);
    if (v < 0) return 8'h00;
    if (v > 255) return 8'hff;
    return v[7:0];
  endfunction

  function automatic void model(input logic [8:0] c, input logic [63:0] a, b, st,
                                output logic [63:0] r, output logic n, output logic bad);
    int s4, s5;
    longint v;
    s4 = int'(st[6:3]);
    s5 = int'(st[7:3]);
    r = '0; n = 0; bad = 0;
    case (c)
      9'h03b: begin
        n = 1;
        for (int i = 0; i < 4; i++) begin
          v = longint'($signed(b[16*i +: 16])) * (longint'(1) << s4);
          r[8*i +: 8] = clamp8(v >>> 7);
        end
      end
      9'h03a: begin
        r = a << 8;
        r[7:0] = 0; r[39:32] = 0;
        for (int w = 0; w < 2; w++) begin
          v = longint'($signed(b[32*w +: 32])) * (longint'(1) << s5);
          r[32*w +: 8] = clamp8(v >>> 23);
        end
      end
      9'h03d: begin
        n = 1;
        for (int w = 0; w < 2; w++) begin
          v = longint'($signed(b[32*w +: 32])) * (longint'(1) << s5);
          v = v >>> 16;
          if (v < -32768) v = -32768;
          if (v > 32767) v = 32767;
          r[16*w +: 16] = v[15:0];
        end
      end
      9'h04d: for (int i = 0; i < 4; i++) r[16*i +: 16] = 16'(b[8*i +: 8]) * 16;
      9'h04b: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8] = b[8*k +: 8];
        r[16*k+8 +: 8] = a[8*k +: 8];
      end
      default: bad = 1;
    endcase
  endfunction

  task automatic run(input string tag, input logic [8:0] c, input logic [63:0] a, b, st);
    logic [63:0] er; logic en, eb;
    model(c, a, b, st, er, en, eb);
    @(negedge clk);
    op = c; src_a = a; src_b = b; status = st; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " result"}, result, er);
    chk("R8 narrow", 64'(narrow), 64'(en));
    chk("R9 illegal", 64'(illegal), 64'(eb));
    chk("R1 out_valid", 64'(out_valid), 64'd1);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold;
    logic [8:0] codes [5] = '{9'h03b, 9'h03a, 9'h03d, 9'h04d, 9'h04b};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 64'(out_valid), 0);
    chk("R1 reset result", result, 0);
    chk("R1 reset flags", {62'd0, narrow, illegal}, 0);
    rst_n = 1;

    run("R3 clamp low/high", 9'h03b, 0, 64'h8000_7fff_0080_ff80, 64'h0);
    run("R3 scale", 9'h03b, 0, 64'h0001_0010_0004_fffe, 64'h20);
    run("R11 pk16 max scale", 9'h03b, 0, 64'h7fff_8000_0001_ffff, 64'h78);
    run("R10 pk16 bit7 ignored", 9'h03b, 0, 64'h0001_0010_0004_0002, 64'hffff_ffff_ffff_ffa7);
    run("R4 pack32", 9'h03a, 64'h1122_3344_5566_7788, 64'h0080_0000_ff00_0000, 64'h0);
    run("R4 pack32 scale", 9'h03a, 64'hffff_ffff_ffff_ffff, 64'h0000_0001_0000_0100, 64'h78);
    run("R11 pk32 max scale", 9'h03a, 0, 64'h7fff_ffff_8000_0000, 64'hf8);
    run("R5 fixed sat", 9'h03d, 0, 64'h7fff_ffff_8000_0000, 64'h08);
    run("R5 fixed exact", 9'h03d, 0, 64'h0000_8000_ffff_0000, 64'h0);
    run("R11 fixed max scale", 9'h03d, 0, 64'h0000_0001_ffff_ffff, 64'hf8);
    run("R10 fixed high status", 9'h03d, 0, 64'h0001_2345_fffe_dcba, 64'hffff_ff00_0000_0010);
    run("R6 expand", 9'h04d, 64'hdead, 64'hffff_ffff_ff80_0100, 0);
    run("R7 merge", 9'h04b, 64'hffff_ffff_a1a2_a3a4, 64'h5555_5555_b1b2_b3b4, 0);
    run("R9 illegal", 9'h1ff, 64'h1234, 64'h5678, 64'h78);
    run("R9 illegal near", 9'h03c, 64'h1234, 64'h5678, 64'h78);

    hold = result;
    @(negedge clk);
    op = 9'h04b; src_a = '1; src_b = '1; status = '1;
    @(negedge clk);
    chk("R2 hold result", result, hold);
    chk("R2 hold illegal", 64'(illegal), 1);
    chk("R1 no strobe", 64'(out_valid), 0);

    for (int i = 0; i < 400; i++) begin
      logic [8:0] c;
      c = ($urandom % 8 == 0) ? 9'($urandom) : codes[$urandom % 5];
      run("R3-7 random", c, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule